// File: doc/BRIEF.md
# Per-Pin GPIO Source Crossbar

This block decides, pin by pin, which internal agent drives the output value and the output enable of two banks of twelve general-purpose pins. Five kinds of driver compete for each pin: a processor register path fed from outside the block, a management register path held inside the block, a user-application fabric port, the ATR outputs of up to two radio slots (two channels per slot), and the SPI signals of those slots. Each pin's data and its output enable always come from the same driver.

Software sets the routing through a bank of 32-bit configuration words on a simple write-strobe / combinational-read bus. Every per-pin word uses the same layout: bank 0 in bits [11:0] and bank 1 in bits [27:16]. A pin's driver is not one select field. Seven separate per-pin bits form a layered decision tree. A per-pin ATR channel bit arrives on an input port with the same layout. Pin inputs pass through a synchronizer into a read-only input word.

Top module: `gpio_route_xbar`

## Requirements
- R1: After reset every configuration word reads zero, and every valid pin carries `app_dout` / `app_doe`.
- R2: Valid pins are bits [11:0] and [27:16] of every word and of every pin bus. Bits [15:12] and [31:28] read as zero, ignore writes, and are driven zero on `pin_out` and `pin_oe`.
- R3: Byte offsets: drive-enable 0x00, management enable 0x04, input word 0x08 (read-only, writes ignored), management data 0x0C, radio-enable 0x10, ATR slot 0x14, SPI slot 0x18, SPI pick 0x1C, processor pick 0x20. A written word reads back masked. Any other offset reads zero and a write to it changes no word.
- R4: A word changes on the rising edge at which `bus_wr_en` is high, and pins follow from that edge on. Before that edge the pins are unchanged.
- R5: With radio-enable 0 and drive-enable 0, a pin carries the user-application port.
- R6: With radio-enable 0, drive-enable 1 and processor pick 1, a pin carries `cpu_dout` / `cpu_doe`.
- R7: With radio-enable 0, drive-enable 1 and processor pick 0, a pin carries the management data word as its value and the management enable word as its output enable (1 = drive).
- R8: With radio-enable 1 and SPI pick 1, a pin carries the SPI signals of the slot named by its SPI slot bit. Slot s occupies `spi_dout[s*32 +: 32]`, and `spi_doe` uses the same layout.
- R9: With radio-enable 1 and SPI pick 0, a pin carries the ATR output of the slot named by its ATR slot bit, on the channel named by its `atr_chan_cfg` bit. Slot s, channel c occupies `atr_dout[(s*2+c)*32 +: 32]`, and `atr_doe` uses the same layout.
- R10: A radio-driven pin whose selected slot has `slot_present[s]` = 0 drives 0 with output enable 0.
- R11: A level on `pin_in` reads back at offset 0x08 after the third rising edge, and not after the second (a two-flop synchronizer followed by the input word).
- R12: Each pin's routing depends only on its own configuration bits, so pins with different settings coexist in one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| atr_chan_cfg | input | 32 | Per-pin ATR channel select |
| slot_present | input | SLOTS | Populated radio slots |
| app_dout | input | 32 | User-application pin values |
| app_doe | input | 32 | User-application output enables |
| cpu_dout | input | 32 | Processor register pin values |
| cpu_doe | input | 32 | Processor register output enables |
| atr_dout | input | SLOTS*64 | ATR values per slot and channel |
| atr_doe | input | SLOTS*64 | ATR output enables per slot and channel |
| spi_dout | input | SLOTS*32 | SPI values per slot |
| spi_doe | input | SLOTS*32 | SPI output enables per slot |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Routed pin values |
| pin_oe | output | 32 | Routed output enables |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_wr_en` hold steady across each rising edge, that every input is a known value after reset, and that `slot_present` does not move within a configuration step. The bench meets these assumptions by changing every input only at falling edges and by holding the source patterns fixed while it reprograms the words. Results are compared against a bench-side routing model derived from R5 through R10.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

   localparam int REG_W = 32;

   localparam int OFF_DRV_EN   = 'h00;
   localparam int OFF_OE_MGMT  = 'h04;
   localparam int OFF_IN_WORD  = 'h08;
   localparam int OFF_DAT_MGMT = 'h0C;
   localparam int OFF_RADIO_EN = 'h10;
   localparam int OFF_ATR_SLOT = 'h14;
   localparam int OFF_SPI_SLOT = 'h18;
   localparam int OFF_SPI_PICK = 'h1C;
   localparam int OFF_CPU_PICK = 'h20;

   typedef struct packed {
      logic [REG_W-1:0] drv_en;
      logic [REG_W-1:0] oe_mgmt;
      logic [REG_W-1:0] dat_mgmt;
      logic [REG_W-1:0] radio_en;
      logic [REG_W-1:0] atr_slot;
      logic [REG_W-1:0] spi_slot;
      logic [REG_W-1:0] spi_pick;
      logic [REG_W-1:0] cpu_pick;
   } route_cfg_t;

   // Valid-bit mask: bank k owns bits [k*stride +: pins]
   function automatic logic [REG_W-1:0] valid_mask(input int banks, input int pins,
                                                    input int stride);
      logic [REG_W-1:0] m;
      m = '0;
      for (int k = 0; k < banks; k++)
         for (int p = 0; p < pins; p++)
            m[k*stride + p] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_route_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BANKS  = 2,
   parameter int PINS   = 12,
   parameter int STRIDE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W-1:0]  in_word,
   output logic [REG_W-1:0]  rdata,
   output route_cfg_t        cfg
);

   localparam logic [REG_W-1:0] MASK = valid_mask(BANKS, PINS, STRIDE);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("gpio_cfg_regs: ADDR_W too small for the word map");
      end
   endgenerate

   route_cfg_t cfg_q;
   logic [REG_W-1:0] wmask;

   assign wmask = wdata & MASK;
   assign cfg   = cfg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         case (addr)
            ADDR_W'(OFF_DRV_EN):   cfg_q.drv_en   <= wmask;
            ADDR_W'(OFF_OE_MGMT):  cfg_q.oe_mgmt  <= wmask;
            ADDR_W'(OFF_DAT_MGMT): cfg_q.dat_mgmt <= wmask;
            ADDR_W'(OFF_RADIO_EN): cfg_q.radio_en <= wmask;
            ADDR_W'(OFF_ATR_SLOT): cfg_q.atr_slot <= wmask;
            ADDR_W'(OFF_SPI_SLOT): cfg_q.spi_slot <= wmask;
            ADDR_W'(OFF_SPI_PICK): cfg_q.spi_pick <= wmask;
            ADDR_W'(OFF_CPU_PICK): cfg_q.cpu_pick <= wmask;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         ADDR_W'(OFF_DRV_EN):   rdata = cfg_q.drv_en;
         ADDR_W'(OFF_OE_MGMT):  rdata = cfg_q.oe_mgmt;
         ADDR_W'(OFF_IN_WORD):  rdata = in_word & MASK;
         ADDR_W'(OFF_DAT_MGMT): rdata = cfg_q.dat_mgmt;
         ADDR_W'(OFF_RADIO_EN): rdata = cfg_q.radio_en;
         ADDR_W'(OFF_ATR_SLOT): rdata = cfg_q.atr_slot;
         ADDR_W'(OFF_SPI_SLOT): rdata = cfg_q.spi_slot;
         ADDR_W'(OFF_SPI_PICK): rdata = cfg_q.spi_pick;
         ADDR_W'(OFF_CPU_PICK): rdata = cfg_q.cpu_pick;
         default:               rdata = '0;
      endcase
   end

   // R4: a strobed write lands on the following edge, masked
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(OFF_RADIO_EN)) |=> (cfg_q.radio_en == ($past(wdata) & MASK)));

   // R2: reserved positions never read as one
   assert_reserved_read_R2: assert property (@(posedge clk) disable iff (rst)
      (rdata & ~MASK) == '0);

   // R3: offsets past the last word, or unaligned, read zero
   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (addr > ADDR_W'(OFF_CPU_PICK) || addr[1:0] != 2'b00) |-> (rdata == '0));

   // R3: a write to the input word or an unmapped offset leaves the words alone
   assert_ignored_write_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (addr == ADDR_W'(OFF_IN_WORD) || addr > ADDR_W'(OFF_CPU_PICK)))
      |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: at least two synchronizer stages are needed");
      end
   endgenerate

   // chain[0..STAGES-1] synchronize, chain[STAGES] is the readable word
   logic [W-1:0] chain [STAGES+1];

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= din;
   end

   generate
      for (genvar k = 1; k <= STAGES; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
         end
      end
   endgenerate

   assign q = chain[STAGES];

endmodule

// File: rtl/gpio_route_core.sv
module gpio_route_core
   import gpio_route_pkg::*;
#(
   parameter logic [REG_W-1:0] MASK = '1
) (
   input  route_cfg_t       cfg,
   input  logic [REG_W-1:0] atr_sel,
   input  logic [1:0]       present,
   input  logic [REG_W-1:0] app_d,
   input  logic [REG_W-1:0] app_e,
   input  logic [REG_W-1:0] cpu_d,
   input  logic [REG_W-1:0] cpu_e,
   input  logic [REG_W-1:0] atr_d [4],
   input  logic [REG_W-1:0] atr_e [4],
   input  logic [REG_W-1:0] spi_d [2],
   input  logic [REG_W-1:0] spi_e [2],
   output logic [REG_W-1:0] pin_d,
   output logic [REG_W-1:0] pin_e
);

   logic [REG_W-1:0] raw_d;
   logic [REG_W-1:0] raw_e;
   logic             slot;

   // Layered choice per pin: radio side first, then register side, then user
   always_comb begin
      raw_d = '0;
      raw_e = '0;
      slot  = 1'b0;
      for (int b = 0; b < REG_W; b++) begin
         slot = cfg.spi_pick[b] ? cfg.spi_slot[b] : cfg.atr_slot[b];
         if (cfg.radio_en[b]) begin
            if (!present[slot]) begin
               raw_d[b] = 1'b0;
               raw_e[b] = 1'b0;
            end else if (cfg.spi_pick[b]) begin
               raw_d[b] = spi_d[slot][b];
               raw_e[b] = spi_e[slot][b];
            end else begin
               raw_d[b] = atr_d[{slot, atr_sel[b]}][b];
               raw_e[b] = atr_e[{slot, atr_sel[b]}][b];
            end
         end else if (cfg.drv_en[b]) begin
            if (cfg.cpu_pick[b]) begin
               raw_d[b] = cpu_d[b];
               raw_e[b] = cpu_e[b];
            end else begin
               raw_d[b] = cfg.dat_mgmt[b];
               raw_e[b] = cfg.oe_mgmt[b];
            end
         end else begin
            raw_d[b] = app_d[b];
            raw_e[b] = app_e[b];
         end
      end
   end

   assign pin_d = raw_d & MASK;
   assign pin_e = raw_e & MASK;

endmodule

// File: rtl/gpio_route_xbar.sv
module gpio_route_xbar
   import gpio_route_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int BANKS       = 2,
   parameter int PINS        = 12,
   parameter int STRIDE      = 16,
   parameter int SLOTS       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_wr_en,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [31:0]           atr_chan_cfg,
   input  logic [SLOTS-1:0]      slot_present,
   input  logic [31:0]           app_dout,
   input  logic [31:0]           app_doe,
   input  logic [31:0]           cpu_dout,
   input  logic [31:0]           cpu_doe,
   input  logic [SLOTS*64-1:0]   atr_dout,
   input  logic [SLOTS*64-1:0]   atr_doe,
   input  logic [SLOTS*32-1:0]   spi_dout,
   input  logic [SLOTS*32-1:0]   spi_doe,
   input  logic [31:0]           pin_in,
   output logic [31:0]           pin_out,
   output logic [31:0]           pin_oe
);

   localparam logic [REG_W-1:0] MASK = valid_mask(BANKS, PINS, STRIDE);
   localparam int CH_PER_SLOT = 2;

   generate
      if (PINS < 1 || PINS > STRIDE) begin : g_bad_pins
         $error("gpio_route_xbar: PINS must fit inside one bank stride");
      end
      if (BANKS < 1 || BANKS * STRIDE > REG_W) begin : g_bad_banks
         $error("gpio_route_xbar: banks do not fit in a register word");
      end
      if (SLOTS < 1 || SLOTS > 2) begin : g_bad_slots
         $error("gpio_route_xbar: one select bit addresses at most two slots");
      end
   endgenerate

   route_cfg_t       cfg;
   logic [REG_W-1:0] in_word;
   logic [1:0]       pres2;
   logic [REG_W-1:0] atr_d4 [4];
   logic [REG_W-1:0] atr_e4 [4];
   logic [REG_W-1:0] spi_d2 [2];
   logic [REG_W-1:0] spi_e2 [2];

   // Widen the slot-side sources to the two slots a select bit can name
   generate
      for (genvar s = 0; s < 2; s++) begin : g_slot
         if (s < SLOTS) begin : g_fit
            assign pres2[s]  = slot_present[s];
            assign spi_d2[s] = spi_dout[s*32 +: 32];
            assign spi_e2[s] = spi_doe[s*32 +: 32];
            for (genvar c = 0; c < CH_PER_SLOT; c++) begin : g_ch
               assign atr_d4[s*CH_PER_SLOT + c] = atr_dout[(s*CH_PER_SLOT + c)*32 +: 32];
               assign atr_e4[s*CH_PER_SLOT + c] = atr_doe[(s*CH_PER_SLOT + c)*32 +: 32];
            end
         end else begin : g_empty
            assign pres2[s]  = 1'b0;
            assign spi_d2[s] = '0;
            assign spi_e2[s] = '0;
            for (genvar c = 0; c < CH_PER_SLOT; c++) begin : g_ch
               assign atr_d4[s*CH_PER_SLOT + c] = '0;
               assign atr_e4[s*CH_PER_SLOT + c] = '0;
            end
         end
      end
   endgenerate

   gpio_cfg_regs #(
      .ADDR_W (ADDR_W),
      .BANKS  (BANKS),
      .PINS   (PINS),
      .STRIDE (STRIDE)
   ) i_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr_en),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .in_word (in_word),
      .rdata   (bus_rdata),
      .cfg     (cfg)
   );

   gpio_in_sync #(
      .W      (REG_W),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_in),
      .q    (in_word)
   );

   gpio_route_core #(
      .MASK (MASK)
   ) i_core (
      .cfg     (cfg),
      .atr_sel (atr_chan_cfg),
      .present (pres2),
      .app_d   (app_dout),
      .app_e   (app_doe),
      .cpu_d   (cpu_dout),
      .cpu_e   (cpu_doe),
      .atr_d   (atr_d4),
      .atr_e   (atr_e4),
      .spi_d   (spi_d2),
      .spi_e   (spi_e2),
      .pin_d   (pin_out),
      .pin_e   (pin_oe)
   );

   // R2: reserved pin positions stay quiet
   assert_reserved_pins_R2: assert property (@(posedge clk) disable iff (rst)
      ((pin_out | pin_oe) & ~MASK) == '0);

   // R5: with no radio and no register ownership, the user port owns every pin
   assert_user_default_R5: assert property (@(posedge clk) disable iff (rst)
      (((cfg.radio_en | cfg.drv_en) & MASK) == '0)
      |-> ((((pin_out ^ app_dout) | (pin_oe ^ app_doe)) & MASK) == '0));

   // R6: register ownership with processor pick on every pin
   assert_cpu_path_R6: assert property (@(posedge clk) disable iff (rst)
      ((cfg.radio_en == '0) && ((cfg.drv_en & cfg.cpu_pick) == MASK))
      |-> ((((pin_out ^ cpu_dout) | (pin_oe ^ cpu_doe)) & MASK) == '0));

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_pin_chk
         if (MASK[b]) begin : g_valid
            // R10: an empty slot never drives a pin
            assert_empty_slot_quiet_R10: assert property (@(posedge clk) disable iff (rst)
               (cfg.radio_en[b] && !pres2[cfg.spi_pick[b] ? cfg.spi_slot[b] : cfg.atr_slot[b]])
               |-> (!pin_out[b] && !pin_oe[b]));
         end
      end
   endgenerate

endmodule

// File: tb/test_gpio_route_xbar.sv
module test_gpio_route_xbar;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] VMASK = 32'h0FFF_0FFF;
   localparam int NVEC = 11;

   // Register table: offset, write value, expected readback (R2, R3)
   localparam logic [7:0]  T_ADDR [NVEC] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18,
                                             8'h1C, 8'h20, 8'h08, 8'h24, 8'h02};
   localparam logic [31:0] T_WR   [NVEC] = '{32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF,
                                             32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hF0F0_F0F0,
                                             32'h0F0F_0F0F, 32'h3333_3333, 32'hFFFF_FFFF,
                                             32'hFFFF_FFFF, 32'hFFFF_FFFF};
   localparam logic [31:0] T_EXP  [NVEC] = '{32'h0FFF_0FFF, 32'h0234_0678, 32'h0EAD_0EEF,
                                             32'h05A5_05A5, 32'h0A5A_0A5A, 32'h00F0_00F0,
                                             32'h0F0F_0F0F, 32'h0333_0333, 32'h0000_0000,
                                             32'h0000_0000, 32'h0000_0000};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] atr_chan_cfg = '0;
   logic [1:0]  slot_present = 2'b11;
   logic [31:0] app_dout, app_doe, cpu_dout, cpu_doe;
   logic [31:0] atr_p [4];
   logic [31:0] spi_p [2];
   logic [127:0] atr_dout, atr_doe;
   logic [63:0]  spi_dout, spi_doe;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;

   // bench-side copies of the configuration words
   logic [31:0] m_drv = '0, m_oe = '0, m_dat = '0, m_radio = '0;
   logic [31:0] m_aslot = '0, m_sslot = '0, m_spick = '0, m_cpick = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   assign atr_dout = {atr_p[3], atr_p[2], atr_p[1], atr_p[0]};
   assign atr_doe  = ~atr_dout;
   assign spi_dout = {spi_p[1], spi_p[0]};
   assign spi_doe  = ~spi_dout;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_route_xbar i_gpio_route_xbar (
      .clk          (clk),
      .rst          (rst),
      .bus_wr_en    (bus_wr_en),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .atr_chan_cfg (atr_chan_cfg),
      .slot_present (slot_present),
      .app_dout     (app_dout),
      .app_doe      (app_doe),
      .cpu_dout     (cpu_dout),
      .cpu_doe      (cpu_doe),
      .atr_dout     (atr_dout),
      .atr_doe      (atr_doe),
      .spi_dout     (spi_dout),
      .spi_doe      (spi_doe),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe)
   );

   // Routing model written from R5..R10
   function automatic logic [31:0] model(input bit want_oe);
      logic [31:0] r;
      logic s;
      logic c;
      r = '0;
      for (int b = 0; b < 32; b++) begin
         if (VMASK[b]) begin
            if (m_radio[b]) begin
               s = m_spick[b] ? m_sslot[b] : m_aslot[b];
               c = atr_chan_cfg[b];
               if (!slot_present[s])  r[b] = 1'b0;
               else if (m_spick[b])   r[b] = want_oe ? ~spi_p[s][b] : spi_p[s][b];
               else                   r[b] = want_oe ? ~atr_p[{s, c}][b] : atr_p[{s, c}][b];
            end else if (m_drv[b]) begin
               if (m_cpick[b]) r[b] = want_oe ? cpu_doe[b] : cpu_dout[b];
               else            r[b] = want_oe ? m_oe[b] : m_dat[b];
            end else begin
               r[b] = want_oe ? app_doe[b] : app_dout[b];
            end
         end
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_pins(input string req);
      chk({req, " pin_out"}, pin_out, model(1'b0));
      chk({req, " pin_oe"},  pin_oe,  model(1'b1));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
      case (a)
         8'h00: m_drv   = d & VMASK;
         8'h04: m_oe    = d & VMASK;
         8'h0C: m_dat   = d & VMASK;
         8'h10: m_radio = d & VMASK;
         8'h14: m_aslot = d & VMASK;
         8'h18: m_sslot = d & VMASK;
         8'h1C: m_spick = d & VMASK;
         8'h20: m_cpick = d & VMASK;
         default: ;
      endcase
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      app_dout = 32'hFAAA_F555;
      app_doe  = 32'hFF0F_F0F0;
      cpu_dout = 32'hFC3C_F3C3;
      cpu_doe  = 32'hFFF0_FF0F;
      atr_p[0] = 32'h0111_0222;
      atr_p[1] = 32'h0333_0444;
      atr_p[2] = 32'h0555_0666;
      atr_p[3] = 32'h0777_0888;
      spi_p[0] = 32'h0123_0456;
      spi_p[1] = 32'h0654_0321;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;

      // R1: reset state
      rd(8'h00, v); chk("R1 drive-enable word", v, 32'h0);
      rd(8'h10, v); chk("R1 radio-enable word", v, 32'h0);
      chk_pins("R1 user port after reset");

      // R2, R3: table walk
      for (int i = 0; i < NVEC; i++) begin
         wr(T_ADDR[i], T_WR[i]);
         rd(T_ADDR[i], v);
         chk($sformatf("R3 readback offset %h (R2 reserved bits)", T_ADDR[i]), v, T_EXP[i]);
      end
      rd(8'h20, v); chk("R3 unmapped writes left processor pick", v, 32'h0333_0333);
      for (int i = 0; i < 8; i++) wr(T_ADDR[i], 32'h0);

      // R4/R6: pick is inert while drive-enable is off, then timing of a write
      wr(8'h20, 32'hFFFF_FFFF);
      chk_pins("R5 pick alone leaves user port");
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
      #1;
      chk("R4 pins unchanged before edge", pin_out, app_dout & VMASK);
      @(negedge clk);
      bus_wr_en = 1'b0;
      m_drv = VMASK;
      #1;
      chk("R4 R6 processor path after edge", pin_out, cpu_dout & VMASK);
      chk_pins("R6 processor path");

      // R7: management path
      wr(8'h20, 32'h0);
      wr(8'h0C, 32'h0A5A_0C3C);
      wr(8'h04, 32'h0F0F_00FF);
      chk_pins("R7 management path");

      // R8: SPI selection
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h18, 32'h0F0F_0F0F);
      chk_pins("R8 SPI by slot bit");

      // R9: ATR selection
      wr(8'h1C, 32'h0);
      wr(8'h14, 32'h00FF_0F0F);
      atr_chan_cfg = 32'h0333_0C3C;
      #1;
      chk_pins("R9 ATR slot and channel");

      // R10: slot 1 unpopulated
      slot_present = 2'b01;
      #1;
      chk_pins("R10 empty slot quiet");
      slot_present = 2'b11;

      // R12: mixed per-pin settings
      wr(8'h10, 32'h0C30_0A50);
      wr(8'h00, 32'h0F0F_05F0);
      wr(8'h20, 32'h0123_0321);
      wr(8'h1C, 32'h0820_0840);
      wr(8'h18, 32'h0FF0_0F00);
      chk_pins("R12 mixed per-pin routing");
      chk("R12 user pins", pin_out & ~(m_radio | m_drv) & VMASK, app_dout & ~(m_radio | m_drv) & VMASK);

      // R11: input synchronizer latency
      @(negedge clk);
      pin_in   = 32'hFFFF_FFFF;
      bus_addr = 8'h08;
      repeat (2) @(negedge clk);
      #1;
      chk("R11 not visible after two edges", bus_rdata, 32'h0);
      @(negedge clk);
      #1;
      chk("R11 visible after third edge", bus_rdata, VMASK);
      wr(8'h08, 32'h0);
      rd(8'h08, v); chk("R11 input word ignores writes", v, VMASK);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule